// File: doc/BRIEF.md
# Interrupt Register Bank Save Controller

This block decides, at each interrupt entry, where the interrupted context goes. It keeps a stack of fifteen hardware register banks. Each bank holds a full register set and the vector number of the interrupt that filled it. The set is fifteen general registers, the global base register, the two multiply-accumulate halves and the procedure return register. The block is told the kind of entry, whether banking is switched on, and whether running out of banks should trap. From that it picks one of three outcomes:

- store the set into the next free bank;
- ask the stack engine to push the set instead;
- raise a bank overflow exception.

The status word and program counter always go to the stack, and the block requests that on every entry.

On return from an ordinary interrupt, a restore request pops the most recent bank onto the context output and moves the bank pointer down. A restore with no occupied bank is refused and flagged. The block performs no memory writes of its own. Stack pushes are only requested through one-cycle pulses.

Top module: `irq_bank_ctl`

## Requirements
- R1: After reset the bank pointer is 0, the full flag is low, every pulse output is low, and the context and vector outputs are zero.
- R2: Every accepted entry, of any kind, produces a one-cycle `sr_pc_push` pulse in the cycle after the entry.
- R3: An entry of kind 0 (ordinary interrupt) with `bank_en` high and fewer than 15 banks occupied stores `ctx_in` and `entry_vec` into bank number `bank_ptr`. On the same edge it raises `bank_saved` for one cycle and increments `bank_ptr`.
- R4: An entry whose kind is not 0 (1 non-maskable, 2 debug break, 3 address error, 4 instruction exception, 5 to 7 reserved), or any entry with `bank_en` low, leaves `bank_ptr` unchanged. It raises none of `bank_saved`, `ctx_push` and `bank_ovf`.
- R5: An ordinary entry with banking enabled while 15 banks are occupied and `ovf_trap_en` is low raises `ctx_push` for one cycle. `bank_ptr` stays at 15.
- R6: The same entry with `ovf_trap_en` high raises `bank_ovf` for one cycle. It does not raise `ctx_push`, and `bank_ptr` stays at 15.
- R7: `bank_full` is high exactly when `bank_ptr` equals 15, and `bank_ptr` never exceeds 15.
- R8: A restore request with `bank_ptr` above 0 decrements the pointer and raises `restore_done` for one cycle. `ctx_out` and `vec_out` take the contents of the most recently filled bank, so banks come back in last-in first-out order.
- R9: A restore request with `bank_ptr` at 0 raises `bank_underflow` for one cycle. It leaves `bank_ptr`, `ctx_out` and `vec_out` unchanged.
- R10: A restore request in the same cycle as an entry is dropped: no `restore_done`, no `bank_underflow`, and `ctx_out` and `vec_out` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_valid | input | 1 | Interrupt entry this cycle |
| entry_kind | input | 3 | Entry kind, 0 = ordinary interrupt |
| bank_en | input | 1 | Bank usage enabled |
| ovf_trap_en | input | 1 | Trap instead of stack fall-back when banks are exhausted |
| entry_vec | input | VW | Vector number of the entry |
| ctx_in | input | NREG*DW | Register set to save, register r at bits r*DW upward |
| restore_req | input | 1 | Pop the most recent bank |
| sr_pc_push | output | 1 | Request to push status word and program counter |
| bank_saved | output | 1 | Register set went into a bank |
| ctx_push | output | 1 | Request to push the register set to the stack |
| bank_ovf | output | 1 | Bank overflow exception |
| restore_done | output | 1 | Restore completed |
| bank_underflow | output | 1 | Restore refused, no bank occupied |
| bank_ptr | output | PW | Number of occupied banks |
| bank_full | output | 1 | All banks occupied |
| ctx_out | output | NREG*DW | Restored register set |
| vec_out | output | VW | Vector number of the restored bank |

## Verification
The save path and the restore path can both be requested on one clock edge, and the rule that the entry wins is the behaviour most likely to go wrong. The bench sends an entry and a restore in the same cycle in several states. It does this with the pointer at 0, where a wrongly served restore would show up as an underflow pulse, and with banks occupied, where it would show up as a restore pulse or a changed context output. It also mixes entry kinds that do and do not save a bank. In each case it expects the pointer to move only by the save, and `ctx_out` and `vec_out` to keep the values of the previous restore.

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl #(
  parameter int DW    = 32,
  parameter int NREG  = 19,
  parameter int NBANK = 15,
  parameter int VW    = 9,
  localparam int PW   = $clog2(NBANK + 1),
  localparam int CW   = NREG * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_valid,
  input  logic [2:0]    entry_kind,
  input  logic          bank_en,
  input  logic          ovf_trap_en,
  input  logic [VW-1:0] entry_vec,
  input  logic [CW-1:0] ctx_in,
  input  logic          restore_req,
  output logic          sr_pc_push,
  output logic          bank_saved,
  output logic          ctx_push,
  output logic          bank_ovf,
  output logic          restore_done,
  output logic          bank_underflow,
  output logic [PW-1:0] bank_ptr,
  output logic          bank_full,
  output logic [CW-1:0] ctx_out,
  output logic [VW-1:0] vec_out
);

  localparam logic [2:0]    KIND_IRQ = 3'd0;
  localparam logic [PW-1:0] TOP      = PW'(NBANK);

  logic [CW-1:0] ctx_mem [NBANK];
  logic [VW-1:0] vec_mem [NBANK];

  wire          want_bank = entry_valid & (entry_kind == KIND_IRQ) & bank_en;
  wire          do_save   = want_bank & ~bank_full;
  wire          do_spill  = want_bank & bank_full & ~ovf_trap_en;
  wire          do_trap   = want_bank & bank_full & ovf_trap_en;
  wire          pop_req   = restore_req & ~entry_valid;
  wire          do_pop    = pop_req & (bank_ptr != '0);
  wire          do_under  = pop_req & (bank_ptr == '0);
  wire [PW-1:0] rd_idx    = bank_ptr - PW'(1);

  assign bank_full = (bank_ptr == TOP);

  always_ff @(posedge clk) begin
    if (do_save) begin
      ctx_mem[bank_ptr] <= ctx_in;
      vec_mem[bank_ptr] <= entry_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_ptr       <= '0;
      sr_pc_push     <= 1'b0;
      bank_saved     <= 1'b0;
      ctx_push       <= 1'b0;
      bank_ovf       <= 1'b0;
      restore_done   <= 1'b0;
      bank_underflow <= 1'b0;
      ctx_out        <= '0;
      vec_out        <= '0;
    end else begin
      sr_pc_push     <= entry_valid;
      bank_saved     <= do_save;
      ctx_push       <= do_spill;
      bank_ovf       <= do_trap;
      restore_done   <= do_pop;
      bank_underflow <= do_under;
      if (do_save)
        bank_ptr <= bank_ptr + PW'(1);
      else if (do_pop)
        bank_ptr <= rd_idx;
      if (do_pop) begin
        ctx_out <= ctx_mem[rd_idx];
        vec_out <= vec_mem[rd_idx];
      end
    end
  end

endmodule

// File: rtl/irq_bank_ctl_chk.sv
module irq_bank_ctl_chk #(
  parameter int PW    = 4,
  parameter int CW    = 608,
  parameter int VW    = 9,
  parameter int NBANK = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          entry_valid,
  input logic [2:0]    entry_kind,
  input logic          bank_en,
  input logic          ovf_trap_en,
  input logic          restore_req,
  input logic          sr_pc_push,
  input logic          bank_saved,
  input logic          ctx_push,
  input logic          bank_ovf,
  input logic          restore_done,
  input logic          bank_underflow,
  input logic [PW-1:0] bank_ptr,
  input logic          bank_full,
  input logic [CW-1:0] ctx_out,
  input logic [VW-1:0] vec_out
);

  // R2
  sr_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |=> sr_pc_push);

  // R3
  bank_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_kind == 3'd0 && bank_en && !bank_full)
    |=> (bank_saved && bank_ptr == PW'($past(bank_ptr) + 1'b1)));

  // R4
  no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && (entry_kind != 3'd0 || !bank_en))
    |=> (!bank_saved && !ctx_push && !bank_ovf && $stable(bank_ptr)));

  // R5
  spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_kind == 3'd0 && bank_en && bank_full && !ovf_trap_en)
    |=> (ctx_push && !bank_ovf && $stable(bank_ptr)));

  // R6
  no_overflow_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_kind == 3'd0 && bank_en && bank_full && ovf_trap_en)
    |=> (bank_ovf && !ctx_push && $stable(bank_ptr)));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ptr <= PW'(NBANK));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_saved, ctx_push, bank_ovf}));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !entry_valid && bank_ptr != '0)
    |=> (restore_done && bank_ptr == PW'($past(bank_ptr) - 1'b1)));

  // R9
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !entry_valid && bank_ptr == '0)
    |=> (bank_underflow && $stable(bank_ptr) && $stable(ctx_out) && $stable(vec_out)));

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && entry_valid)
    |=> (!restore_done && !bank_underflow && $stable(ctx_out) && $stable(vec_out)));

endmodule

bind irq_bank_ctl irq_bank_ctl_chk #(.PW(PW), .CW(CW), .VW(VW), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_kind(entry_kind),
  .bank_en(bank_en), .ovf_trap_en(ovf_trap_en), .restore_req(restore_req),
  .sr_pc_push(sr_pc_push), .bank_saved(bank_saved), .ctx_push(ctx_push),
  .bank_ovf(bank_ovf), .restore_done(restore_done), .bank_underflow(bank_underflow),
  .bank_ptr(bank_ptr), .bank_full(bank_full), .ctx_out(ctx_out), .vec_out(vec_out)
);

// File: tb/irq_bank_ctl_bench.sv
module irq_bank_ctl_bench;
  localparam int CLK_NS = 10;
  localparam int DW     = 8;
  localparam int NREG   = 19;
  localparam int NBANK  = 15;
  localparam int VW     = 9;
  localparam int PW     = 4;
  localparam int CW     = NREG * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          entry_valid = 1'b0;
  logic [2:0]    entry_kind = '0;
  logic          bank_en = 1'b0;
  logic          ovf_trap_en = 1'b0;
  logic [VW-1:0] entry_vec = '0;
  logic [CW-1:0] ctx_in = '0;
  logic          restore_req = 1'b0;
  logic          sr_pc_push, bank_saved, ctx_push, bank_ovf;
  logic          restore_done, bank_underflow, bank_full;
  logic [PW-1:0] bank_ptr;
  logic [CW-1:0] ctx_out;
  logic [VW-1:0] vec_out;

  irq_bank_ctl #(.DW(DW), .NREG(NREG), .NBANK(NBANK), .VW(VW)) u_irq_bank_ctl (
    .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_kind(entry_kind),
    .bank_en(bank_en), .ovf_trap_en(ovf_trap_en), .entry_vec(entry_vec),
    .ctx_in(ctx_in), .restore_req(restore_req), .sr_pc_push(sr_pc_push),
    .bank_saved(bank_saved), .ctx_push(ctx_push), .bank_ovf(bank_ovf),
    .restore_done(restore_done), .bank_underflow(bank_underflow),
    .bank_ptr(bank_ptr), .bank_full(bank_full), .ctx_out(ctx_out), .vec_out(vec_out)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int            m_ptr = 0;
  logic [CW-1:0] m_ctx [NBANK];
  logic [VW-1:0] m_vec [NBANK];
  logic [CW-1:0] x_ctx = '0;
  logic [VW-1:0] x_vec = '0;

  function automatic logic [CW-1:0] pat(input int n);
    logic [CW-1:0] v;
    for (int r = 0; r < NREG; r++) v[r*DW +: DW] = DW'(n * 7 + r * 13 + 1);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_ctx(input string tag);
    n_chk++;
    if (ctx_out !== x_ctx || vec_out !== x_vec) begin
      n_bad++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", tag, ctx_out, vec_out, x_ctx, x_vec);
    end
  endtask

  task automatic op(input bit ent, input bit [2:0] kind, input bit en, input bit trap,
                    input bit rst_rq, input int seed);
    bit want, e_save, e_spill, e_trap, pop, e_done, e_under;
    int p0;
    p0      = m_ptr;
    want    = ent && kind == 3'd0 && en;
    e_save  = want && m_ptr < NBANK;
    e_spill = want && m_ptr == NBANK && !trap;
    e_trap  = want && m_ptr == NBANK && trap;
    pop     = rst_rq && !ent;
    e_done  = pop && m_ptr > 0;
    e_under = pop && m_ptr == 0;
    if (e_save) begin
      m_ctx[m_ptr] = pat(seed);
      m_vec[m_ptr] = VW'(seed);
      m_ptr++;
    end
    if (e_done) begin
      m_ptr--;
      x_ctx = m_ctx[m_ptr];
      x_vec = m_vec[m_ptr];
    end
    @(negedge clk);
    entry_valid = ent; entry_kind = kind; bank_en = en; ovf_trap_en = trap;
    entry_vec = VW'(seed); ctx_in = pat(seed); restore_req = rst_rq;
    @(posedge clk);
    #1;
    chk(sr_pc_push === ent, "R2 sr_pc_push", sr_pc_push, ent);
    chk(bank_saved === e_save, "R3 bank_saved", bank_saved, e_save);
    chk(int'(bank_ptr) == m_ptr, "R3 bank_ptr", bank_ptr, m_ptr);
    chk(ctx_push === e_spill, "R5 ctx_push", ctx_push, e_spill);
    chk(bank_ovf === e_trap, "R6 bank_ovf", bank_ovf, e_trap);
    chk(bank_full === (m_ptr == NBANK), "R7 bank_full", bank_full, m_ptr == NBANK);
    chk(restore_done === e_done, "R8 restore_done", restore_done, e_done);
    chk(bank_underflow === e_under, "R9 bank_underflow", bank_underflow, e_under);
    chk_ctx("R8 ctx_out/vec_out");
    if (ent && !want)
      chk(int'(bank_ptr) == p0 && !bank_saved && !ctx_push && !bank_ovf,
          "R4 no bank effect", bank_ptr, p0);
    if (ent && rst_rq) begin
      chk(!restore_done && !bank_underflow, "R10 restore dropped", restore_done, 0);
      chk_ctx("R10 ctx unchanged");
    end
    @(negedge clk);
    entry_valid = 1'b0; restore_req = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    s = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(bank_ptr === '0 && !bank_full, "R1 reset pointer", bank_ptr, 0);
    chk(!sr_pc_push && !bank_saved && !ctx_push && !bank_ovf && !restore_done && !bank_underflow,
        "R1 reset pulses", 1, 0);
    chk(ctx_out === '0 && vec_out === '0, "R1 reset context", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;

    op(0, 0, 0, 0, 1, s++);
    op(1, 0, 1, 0, 1, s++);
    op(0, 0, 0, 0, 1, s++);
    for (int k = 0; k < 8; k++)
      for (int e = 0; e < 2; e++)
        op(1, 3'(k), e[0], 0, 0, s++);
    for (int f = 0; f < NBANK; f++) begin
      op(1, 0, 1, f[0], 0, s++);
      op(1, 3'(1 + f % 4), 1, 0, 0, s++);
    end
    for (int t = 0; t < 2; t++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 3; k++)
          op(1, 3'(k), e[0], t[0], 0, s++);
    op(1, 0, 1, 1, 1, s++);
    op(1, 0, 1, 0, 1, s++);
    for (int r = 0; r < 6; r++) op(0, 0, 0, 0, 1, s++);
    op(1, 0, 1, 0, 1, s++);
    op(1, 2, 1, 0, 1, s++);
    op(0, 0, 0, 0, 1, s++);
    for (int r = 0; r < NBANK; r++) op(0, 0, 0, 0, 1, s++);
    for (int r = 0; r < 40; r++)
      op((r % 3) != 2, 3'((r * 5) % 8 < 4 ? 0 : (r % 5)), r % 7 != 3, r[1], (r % 3) != 0, s++);
    while (m_ptr > 0) op(0, 0, 0, 0, 1, s++);
    op(0, 0, 0, 0, 1, s++);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule